// File: doc/BRIEF.md
# Prescaled serial bit-rate generator

This block derives the bit-timing strobes for an asynchronous serial port from the peripheral clock. Software writes a 2-bit clock-select value, which picks a fixed prescaler of 1, 4, 16 or 64, and an 8-bit count N. The block then issues a one-cycle 16x oversampling strobe every 2 × prescale × (N+1) clocks, and a one-cycle bit strobe on every sixteenth oversampling strobe. One bit therefore lasts 32 × prescale × (N+1) clocks. Software picks the prescaler and N for the wanted baud rate, using the smallest prescaler for which N still fits in 8 bits. The block does not compute these values.

An enable input, driven from the port's transmit or receive enable, gates the whole divider chain. Writing either configuration register restarts the chain from zero. The first period after a change therefore always has its full length.

Top module: `brg_top`

## Requirements
- R1: The clock-select value is bits 1:0 of the register at write address 0. Value 0 selects prescale 1, value 1 selects 4, value 2 selects 16, and value 3 selects 64.
- R2: The count N is the 8-bit value written to address 1, and any N from 0 to 255 is accepted.
- R3: While enabled and with no write, `os_tick` is high for exactly one clock every 2 × prescale × (N+1) clocks.
- R4: `bit_tick` is high only together with `os_tick`, on every 16th oversampling strobe, so its spacing is 32 × prescale × (N+1) clocks.
- R5: A write to either register restarts the chain. Counting the cycle after the write as the first, the next `os_tick` comes in the 2 × prescale × (N+1)-th cycle, using the new settings.
- R6: While `enable` is low, no strobe is produced and the chain is held at zero. After `enable` rises, the first `os_tick` comes one full period later, in the same way as after a write.
- R7: Reset sets clock-select to 0 and N to 0, and no strobe is produced during reset. With `enable` high after reset, the first `os_tick` comes in the second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the divider chain when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = clock-select register, 1 = count register |
| wr_data | input | 8 | Write data |
| os_tick | output | 1 | 16x oversampling strobe |
| bit_tick | output | 1 | Bit-period strobe |

## Verification
All four prescaler settings are run with N = 0 and N = 1. Together these separate the prescaler's contribution from the counter's and catch a wrong prescale encoding. N = 255 is run with the smallest and the largest prescaler, which exposes a truncated count width and an off-by-one in the terminal count. Writes made in the middle of a period, and enable pulses, show whether a restart yields a full first period and whether the chain stays silent while disabled.

// File: rtl/brg_pkg.sv
package brg_pkg;

    typedef enum logic [1:0] {
        PS_DIV1  = 2'd0,
        PS_DIV4  = 2'd1,
        PS_DIV16 = 2'd2,
        PS_DIV64 = 2'd3
    } presc_e;

    localparam int PRE_W = 6;

    // terminal count of the prescaler for each select value
    function automatic logic [PRE_W-1:0] presc_last(presc_e sel);
        case (sel)
            PS_DIV1:  presc_last = 6'd0;
            PS_DIV4:  presc_last = 6'd3;
            PS_DIV16: presc_last = 6'd15;
            default:  presc_last = 6'd63;
        endcase
    endfunction

endpackage

// File: rtl/brg_prescaler.sv
module brg_prescaler
    import brg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run,
    input  logic   clr,
    input  presc_e sel,
    output logic   pre_tick
);
    typedef struct packed {
        logic [PRE_W-1:0] pc;
    } st_t;

    st_t st_d, st_q;
    logic [PRE_W-1:0] last;

    always_comb begin
        last     = presc_last(sel);
        pre_tick = run && (st_q.pc == last);
        st_d     = st_q;
        if (clr)
            st_d.pc = '0;
        else if (st_q.pc == last)
            st_d.pc = '0;
        else
            st_d.pc = st_q.pc + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> st_q.pc == '0); // R1
endmodule

// File: rtl/brg_divider.sv
module brg_divider #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             pre_tick,
    input  logic [CNT_W-1:0] n,
    output logic             os_tick
);
    typedef struct packed {
        logic [CNT_W-1:0] dc;
        logic             half;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        os_tick = pre_tick && (st_q.dc == n) && st_q.half;
        st_d    = st_q;
        if (clr) begin
            st_d = '0;
        end else if (pre_tick) begin
            if (st_q.dc == n) begin
                st_d.dc   = '0;
                st_d.half = ~st_q.half;
            end else begin
                st_d.dc = st_q.dc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> st_q.dc <= n); // R2
    AST_OS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        os_tick |=> !os_tick); // R3
endmodule

// File: rtl/brg_oversample.sv
module brg_oversample #(
    parameter int RATIO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic os_tick,
    output logic bit_tick
);
    localparam int OC_W = $clog2(RATIO);
    localparam logic [OC_W-1:0] OC_LAST = OC_W'(RATIO - 1);

    typedef struct packed {
        logic [OC_W-1:0] oc;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        bit_tick = os_tick && (st_q.oc == OC_LAST);
        st_d     = st_q;
        if (clr)
            st_d.oc = '0;
        else if (os_tick)
            st_d.oc = (st_q.oc == OC_LAST) ? '0 : st_q.oc + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_BIT_WITH_OS: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick); // R4
endmodule

// File: rtl/brg_top.sv
module brg_top
    import brg_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int OS_RATIO = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             os_tick,
    output logic             bit_tick
);
    typedef struct packed {
        presc_e           cs;
        logic [CNT_W-1:0] n;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic restart_d;
    logic pre_tick;

    always_comb begin
        cfg_d     = cfg_q;
        restart_d = wr_en || !enable;
        if (wr_en) begin
            if (wr_addr == 1'b0) cfg_d.cs = presc_e'(wr_data[1:0]);
            else                 cfg_d.n  = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{cs: PS_DIV1, n: '0};
        else        cfg_q <= cfg_d;
    end

    brg_prescaler u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (enable),
        .clr      (restart_d),
        .sel      (cfg_q.cs),
        .pre_tick (pre_tick)
    );

    brg_divider #(.CNT_W(CNT_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (restart_d),
        .pre_tick (pre_tick),
        .n        (cfg_q.n),
        .os_tick  (os_tick)
    );

    brg_oversample #(.RATIO(OS_RATIO)) u_os (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (restart_d),
        .os_tick  (os_tick),
        .bit_tick (bit_tick)
    );

    AST_QUIET_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> !os_tick); // R5
    AST_QUIET_AFTER_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!enable) |-> !os_tick && !bit_tick); // R6
endmodule

// File: tb/tb_brg_top.sv
module tb_brg_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       os_tick, bit_tick;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    brg_top dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .os_tick(os_tick), .bit_tick(bit_tick)
    );

    // behavioural reference: cycles since the chain was last zeroed
    int m_cs = 0, m_n = 0, m_cnt = 0, epoch = 0;

    function automatic int pscale(int cs);
        return (cs == 0) ? 1 : (cs == 1) ? 4 : (cs == 2) ? 16 : 64;
    endfunction

    function automatic int m_per();
        return 2 * pscale(m_cs) * (m_n + 1);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cs = 0; m_n = 0; m_cnt = 0; epoch = epoch + 1;
        end else begin
            if (wr_en) begin
                if (wr_addr == 1'b0) m_cs = int'(wr_data[1:0]);
                else                 m_n  = int'(wr_data);
            end
            if (!enable || wr_en) begin
                m_cnt = 0; epoch = epoch + 1;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison and tick spacing measurement
    int cyc = 0, last_os = -1, last_bit = -1, os_ep = -1, bit_ep = -1;
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n && !done) begin
            bit e_os, e_bit;
            e_os  = enable && (((m_cnt + 1) % m_per()) == 0);
            e_bit = enable && (((m_cnt + 1) % (16 * m_per())) == 0);
            check(os_tick == e_os, "R3 os_tick per cycle", int'(os_tick), int'(e_os));
            check(bit_tick == e_bit, "R4 bit_tick per cycle", int'(bit_tick), int'(e_bit));
            if (os_tick) begin
                if (os_ep == epoch)
                    check(cyc - last_os == m_per(), "R1 R2 R3 os spacing", cyc - last_os, m_per());
                last_os = cyc; os_ep = epoch;
            end
            if (bit_tick) begin
                if (bit_ep == epoch)
                    check(cyc - last_bit == 16 * m_per(), "R4 bit spacing", cyc - last_bit, 16 * m_per());
                last_bit = cyc; bit_ep = epoch;
            end
        end
    end

    task automatic wr(input bit a, input int d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = 8'(d);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // cycles until the first os tick, counting from the current cycle as 1
    task automatic first_gap(output int k);
        k = 0;
        for (int i = 1; i <= 70000; i++) begin
            @(negedge clk);
            if (os_tick) begin k = i; break; end
        end
    endtask

    task automatic run_cfg(input int cs, input int n, input int cyc_lim);
        int per, len;
        wr(1'b0, cs);
        wr(1'b1, n);
        per = 2 * pscale(cs) * (n + 1);
        len = 3 * 16 * per + 10;
        if (len > cyc_lim) len = cyc_lim;
        repeat (len) @(posedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        finish_run();
    end

    initial begin
        int k;
        // R7: quiet during reset
        enable = 1'b1;
        repeat (5) begin
            @(negedge clk);
            check(!os_tick && !bit_tick, "R7 no strobe in reset", int'(os_tick | bit_tick), 0);
        end
        @(posedge clk); #1; rst_n = 1'b1;
        first_gap(k);
        check(k == 2, "R7 reset defaults period", k, 2);

        // R1 R2: all prescalers, N = 0 and 1
        for (int cs = 0; cs < 4; cs++) begin
            run_cfg(cs, 0, 70000);
            run_cfg(cs, 1, 70000);
        end
        // R2: full count range
        run_cfg(0, 255, 70000);
        run_cfg(3, 255, 66000);

        // R5: write mid-period restarts with new settings
        wr(1'b0, 1); wr(1'b1, 2);
        repeat (7) @(posedge clk);
        wr(1'b1, 5);
        first_gap(k);
        check(k == 48, "R5 restart after count write", k, 48);
        repeat (13) @(posedge clk);
        wr(1'b0, 2);
        first_gap(k);
        check(k == 192, "R5 restart after select write", k, 192);

        // R6: disable holds, enable restarts full period
        wr(1'b0, 0); wr(1'b1, 3);
        repeat (3) @(posedge clk); #1;
        enable = 1'b0;
        k = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (os_tick || bit_tick) k++;
        end
        check(k == 0, "R6 no strobes while disabled", k, 0);
        @(posedge clk); #1; enable = 1'b1;
        first_gap(k);
        check(k == 8, "R6 first period after enable", k, 8);
        repeat (300) @(posedge clk);

        finish_run();
    end
endmodule